// File: doc/BRIEF.md
# Fetch-Group Last-Outcome Branch Predictor

This block gives the next fetch address for an aligned group of four 4-byte instructions, in the same cycle as the lookup. It holds two separate structures. The first is a direction table of one-bit entries, each recording whether the branch that maps to it went taken on its most recent execution. The second is a small set-associative target cache that holds the full target address of each branch. A slot of the group redirects fetch only when three things are true: its address hits in the target cache, its direction bit says taken, and the fetch stage has not flagged it as an indirect branch. The lowest such slot wins. When no slot qualifies, fetch continues with the next sequential group.

An update port carries each resolved branch: its address, its outcome and its target. That update rewrites the direction bit. A taken branch that is not yet in the cache is placed into the least recently used way of its set. Any update that hits, or that allocates, makes that way the most recently used. Updates that are marked indirect are dropped completely.

Top module: `bp_fetch_lasttime`

## Requirements
- R1: After reset every direction bit is not-taken and every cache way is empty, so a lookup of any group returns the group address plus 16, with pred_taken low.
- R2: When no slot qualifies, pred_next is the group base plus 16 and pred_taken is low. The group base is lk_pc with its low four bits cleared, so those bits are ignored.
- R3: Slot i (address base + 4*i) qualifies only when all of these hold: a valid cache way in set address[2] has tag address[31:3]; the direction bit at address[7:2] is 1; and lk_indirect[i] is 0.
- R4: When several slots qualify, pred_slot is the lowest qualifying slot number, and pred_next is that slot's target.
- R5: An update with up_valid=1 and up_indirect=0 writes up_taken into the direction bit at up_pc[7:2]. The next lookup follows the latest outcome, even when the target is still cached.
- R6: The target cache holds the exact 32-bit target. A taken update that hits replaces the stored target with up_target.
- R7: A taken update that misses its set is written into the least recently used way of that set. With four ways, a fifth distinct branch evicts the one least recently touched.
- R8: An update that hits (taken or not taken), or that allocates, makes that way the most recently used in its set. A not-taken update that misses allocates nothing.
- R9: An update with up_indirect=1 changes neither the direction table nor the target cache.
- R10: A lookup sees the state from before an update presented in the same cycle. The update becomes visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch group address (low 4 bits ignored) |
| lk_indirect | input | 4 | Per-slot flag marking an indirect branch |
| pred_next | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | A slot redirected the fetch |
| pred_slot | output | 2 | Slot that supplied the redirect |
| up_valid | input | 1 | Resolved-branch update present |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome |
| up_indirect | input | 1 | Resolved branch was indirect |
| up_target | input | 32 | Resolved target address |

## Verification
Lookup and update can fall in the same cycle, and they can touch the same branch. The bench sets this up by presenting a lookup of a group together with a taken update to a slot of that same group. It checks that the prediction in that cycle comes from the old state, and that the lookup in the next cycle picks up the new, lower slot. Every lookup is compared against a reference model. The model applies each update only after it has taken that cycle's expected prediction. The cases covered include several qualifying slots being masked one by one, and eviction order after not-taken updates have touched the replacement state.

// File: rtl/bp_fetch_lasttime.sv
module bp_fetch_lasttime #(
  parameter int AW    = 32,
  parameter int SLOTS = 4,
  parameter int BPT_N = 64,
  parameter int SETS  = 2,
  parameter int WAYS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     lk_pc,
  input  logic [SLOTS-1:0]  lk_indirect,
  output logic [AW-1:0]     pred_next,
  output logic              pred_taken,
  output logic [$clog2(SLOTS)-1:0] pred_slot,
  input  logic              up_valid,
  input  logic [AW-1:0]     up_pc,
  input  logic              up_taken,
  input  logic              up_indirect,
  input  logic [AW-1:0]     up_target
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BPT_W  = $clog2(BPT_N);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = AW - 2 - SET_W;
  localparam int GRP_B  = SLOTS * 4;
  localparam logic [AW-1:0] GRP_MASK = ~(AW'(GRP_B) - AW'(1));

  logic [BPT_N-1:0] bpt_q;
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [AW-1:0]    tgt_q [SETS][WAYS];
  logic             vld_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  logic [AW-1:0] base;
  assign base = lk_pc & GRP_MASK;

  logic [SLOTS-1:0] slot_ok;
  logic [AW-1:0]    slot_tgt [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [AW-1:0]    spc;
    logic [SET_W-1:0] sset;
    logic [TAG_W-1:0] stag;
    logic             shit;
    logic [AW-1:0]    stgt;
    assign spc  = base + AW'(4 * g);
    assign sset = spc[2 +: SET_W];
    assign stag = spc[AW-1 -: TAG_W];
    always_comb begin
      shit = 1'b0;
      stgt = '0;
      for (int w = 0; w < WAYS; w++)
        if (vld_q[sset][w] && tag_q[sset][w] == stag) begin
          shit = 1'b1;
          stgt = tgt_q[sset][w];
        end
    end
    assign slot_ok[g]  = shit & bpt_q[spc[2 +: BPT_W]] & ~lk_indirect[g];
    assign slot_tgt[g] = stgt;
  end

  always_comb begin
    pred_taken = 1'b0;
    pred_slot  = '0;
    pred_next  = base + AW'(GRP_B);
    for (int i = SLOTS - 1; i >= 0; i--)
      if (slot_ok[i]) begin
        pred_taken = 1'b1;
        pred_slot  = SLOT_W'(i);
        pred_next  = slot_tgt[i];
      end
  end

  logic [SET_W-1:0] u_set;
  logic [TAG_W-1:0] u_tag;
  logic [BPT_W-1:0] u_bidx;
  logic             u_hit, u_live, u_touch, u_write;
  logic [WAY_W-1:0] u_hway, u_vict, u_way;

  assign u_set  = up_pc[2 +: SET_W];
  assign u_tag  = up_pc[AW-1 -: TAG_W];
  assign u_bidx = up_pc[2 +: BPT_W];
  assign u_live = up_valid & ~up_indirect;

  always_comb begin
    u_hit  = 1'b0;
    u_hway = '0;
    u_vict = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[u_set][w] && tag_q[u_set][w] == u_tag) begin
        u_hit  = 1'b1;
        u_hway = WAY_W'(w);
      end
      if (age_q[u_set][w] == WAY_W'(WAYS - 1)) u_vict = WAY_W'(w);
    end
  end

  assign u_way   = u_hit ? u_hway : u_vict;
  assign u_touch = u_live & (u_hit | up_taken);
  assign u_write = u_live & up_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bpt_q <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
          tgt_q[s][w] <= '0;
          age_q[s][w] <= WAY_W'(w);
        end
    end else begin
      if (u_live) bpt_q[u_bidx] <= up_taken;
      if (u_write) begin
        vld_q[u_set][u_way] <= 1'b1;
        tag_q[u_set][u_way] <= u_tag;
        tgt_q[u_set][u_way] <= up_target;
      end
      if (u_touch)
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == u_way) age_q[u_set][w] <= '0;
          else if (age_q[u_set][w] < age_q[u_set][u_way])
            age_q[u_set][w] <= age_q[u_set][w] + WAY_W'(1);
    end
  end

  // ---------------- assertions ----------------
  logic [SETS*WAYS-1:0] vld_flat;
  logic [WAYS-1:0]      age_seen [SETS];
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      age_seen[s] = '0;
      for (int w = 0; w < WAYS; w++) begin
        vld_flat[s*WAYS+w] = vld_q[s][w];
        age_seen[s][age_q[s][w]] = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    p_lru_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      age_seen[s] == {WAYS{1'b1}});
  end

  p_first_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> slot_ok[pred_slot] &&
                   ((slot_ok & ((SLOTS'(1) << pred_slot) - SLOTS'(1))) == '0));

  p_idle_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_ok == '0) |-> (!pred_taken && pred_next == base + AW'(GRP_B)));

  p_last_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    u_live |=> bpt_q[$past(u_bidx)] == $past(up_taken));

  p_indirect_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_indirect) |=> $stable(bpt_q) && $stable(vld_flat));

  p_touch_mru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    u_touch |=> age_q[$past(u_set)][$past(u_way)] == '0);

endmodule

// File: tb/test_bp_fetch_lasttime.sv
`timescale 1ns/1ps
module test_bp_fetch_lasttime;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [3:0]  lk_indirect = '0;
  logic [31:0] pred_next;
  logic        pred_taken;
  logic [1:0]  pred_slot;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic        up_indirect = 1'b0;
  logic [31:0] up_target = '0;

  always #5 clk = ~clk;

  bp_fetch_lasttime i_bp_fetch_lasttime (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_indirect(lk_indirect),
    .pred_next(pred_next), .pred_taken(pred_taken), .pred_slot(pred_slot),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_indirect(up_indirect), .up_target(up_target));

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] q_nxt [$];
  logic        q_tk  [$];
  logic [1:0]  q_sl  [$];
  string       q_req [$];

  // reference model
  bit          m_bpt [64];
  logic [28:0] m_tag [2][4];
  logic [31:0] m_tgt [2][4];
  bit          m_v   [2][4];
  int          m_age [2][4];

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_bpt[i] = 0;
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 0; m_tag[s][w] = '0; m_tgt[s][w] = '0; m_age[s][w] = w;
      end
  endtask

  task automatic model_predict(input logic [31:0] pc, input logic [3:0] ind,
                               output logic [31:0] nxt, output logic tk,
                               output logic [1:0] sl);
    logic [31:0] b;
    b = {pc[31:4], 4'b0};
    nxt = b + 32'd16; tk = 0; sl = 0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      a = b + 32'(4 * i);
      if (!tk && !ind[i] && m_bpt[a[7:2]])
        for (int w = 0; w < 4; w++)
          if (m_v[a[2]][w] && m_tag[a[2]][w] == a[31:3]) begin
            tk = 1; sl = 2'(i); nxt = m_tgt[a[2]][w];
          end
    end
  endtask

  task automatic model_update(input logic [31:0] pc, input logic t,
                              input logic [31:0] tgt, input logic ind);
    int s, way, hw;
    if (ind) return;
    m_bpt[pc[7:2]] = t;
    s = int'(pc[2]);
    hw = -1;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_tag[s][w] == pc[31:3]) hw = w;
    if (hw < 0 && !t) return;
    way = hw;
    if (hw < 0)
      for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) way = w;
    if (t) begin
      m_v[s][way] = 1; m_tag[s][way] = pc[31:3]; m_tgt[s][way] = tgt;
    end
    for (int w = 0; w < 4; w++)
      if (w != way && m_age[s][w] < m_age[s][way]) m_age[s][w]++;
    m_age[s][way] = 0;
  endtask

  // driver: one lookup (and optional update) per cycle
  task automatic cyc(input logic [31:0] pc, input logic [3:0] ind,
                     input logic uv, input logic [31:0] upc, input logic ut,
                     input logic ui, input logic [31:0] utgt, input string req);
    logic [31:0] e_n; logic e_t; logic [1:0] e_s;
    @(posedge clk); #1;
    lk_pc = pc; lk_indirect = ind;
    up_valid = uv; up_pc = upc; up_taken = ut; up_indirect = ui; up_target = utgt;
    model_predict(pc, ind, e_n, e_t, e_s);
    q_nxt.push_back(e_n); q_tk.push_back(e_t); q_sl.push_back(e_s); q_req.push_back(req);
    if (uv) model_update(upc, ut, utgt, ui);
  endtask

  task automatic look(input logic [31:0] pc, input logic [3:0] ind, input string req);
    cyc(pc, ind, 1'b0, '0, 1'b0, 1'b0, '0, req);
  endtask

  task automatic upd(input logic [31:0] upc, input logic t, input logic [31:0] tgt,
                     input logic ui, input string req);
    cyc(upc, 4'b0, 1'b1, upc, t, ui, tgt, req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && q_nxt.size() > 0) begin
      logic [31:0] e_n; logic e_t; logic [1:0] e_s; string r;
      e_n = q_nxt.pop_front(); e_t = q_tk.pop_front();
      e_s = q_sl.pop_front();  r = q_req.pop_front();
      n_vec++;
      if (pred_next !== e_n || pred_taken !== e_t || (e_t && pred_slot !== e_s)) begin
        n_bad++;
        $display("FAIL %s: next=%h taken=%b slot=%0d expected next=%h taken=%b slot=%0d",
                 r, pred_next, pred_taken, pred_slot, e_n, e_t, e_s);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look(32'h1000, 4'b0, "R1");
    look(32'h7F30, 4'b0, "R1");
    look(32'h100C, 4'b0, "R2 low bits ignored");
    upd(32'h1008, 1, 32'h2000, 0, "R7 first allocate");
    look(32'h1000, 4'b0, "R6 exact target slot2");
    look(32'h1004, 4'b0, "R2 low bits ignored on hit");
    // coincident lookup and update of same group
    cyc(32'h1000, 4'b0, 1, 32'h1004, 1, 0, 32'h3000, "R10 old state in same cycle");
    look(32'h1000, 4'b0, "R10 update visible next cycle / R4");
    look(32'h1000, 4'b0010, "R3 indirect flag masks slot1");
    look(32'h1000, 4'b0110, "R3 all masked gives sequential");
    upd(32'h1004, 0, 32'h0, 0, "R5 not-taken update");
    look(32'h1000, 4'b0, "R5 cached but not-taken skips slot1");
    upd(32'h1004, 1, 32'h3400, 0, "R6 retarget");
    look(32'h1000, 4'b0, "R6 new target slot1");
    // fill set 0 and exercise eviction order
    upd(32'h4000, 1, 32'hA000, 0, "R7 fill A");
    upd(32'h4010, 1, 32'hB000, 0, "R7 fill B");
    upd(32'h4020, 1, 32'hC000, 0, "R7 fill C");
    upd(32'h4030, 1, 32'hD000, 0, "R7 fill D evicts oldest");
    look(32'h1000, 4'b0, "R7 0x1008 evicted");
    look(32'h4000, 4'b0, "R7 A still present");
    upd(32'h4010, 1, 32'hB000, 0, "R8 touch B");
    upd(32'h4040, 1, 32'hE000, 0, "R7 E evicts A");
    look(32'h4000, 4'b0, "R7 A evicted after B touched");
    look(32'h4010, 4'b0, "R8 B survives");
    upd(32'h4020, 0, 32'h0, 0, "R8 not-taken touch C");
    upd(32'h4050, 1, 32'hF000, 0, "R8 F evicts D not C");
    look(32'h4030, 4'b0, "R8 D evicted");
    upd(32'h4020, 1, 32'hC800, 0, "R8 C still cached");
    look(32'h4020, 4'b0, "R8 C hit with new target");
    upd(32'h6004, 0, 32'h0, 0, "R8 not-taken miss allocates nothing");
    look(32'h4040, 4'b0, "R8 E unaffected");
    // indirect updates ignored
    upd(32'h4010, 1, 32'h9990, 1, "R9 indirect taken");
    look(32'h4010, 4'b0, "R9 target unchanged");
    upd(32'h4010, 0, 32'h0, 1, "R9 indirect not-taken");
    look(32'h4010, 4'b0, "R9 direction unchanged");
    upd(32'h5100, 1, 32'h5500, 1, "R9 indirect miss");
    look(32'h5100, 4'b0, "R9 no allocation");
    // several qualifying slots
    upd(32'h5204, 1, 32'h8104, 0, "R4 fill slot1");
    upd(32'h520C, 1, 32'h810C, 0, "R4 fill slot3");
    upd(32'h5200, 1, 32'h8100, 0, "R4 fill slot0");
    upd(32'h5208, 1, 32'h8108, 0, "R4 fill slot2");
    look(32'h5200, 4'b0000, "R4 slot0 wins");
    look(32'h5200, 4'b0001, "R4 slot1 next");
    look(32'h5200, 4'b0011, "R4 slot2 next");
    look(32'h5200, 4'b0111, "R4 slot3 last");
    look(32'h5200, 4'b1111, "R3 all indirect");
    upd(32'h5200, 0, 32'h0, 0, "R5 slot0 not-taken");
    look(32'h5200, 4'b0, "R5 slot1 after slot0 went not-taken");
    look(32'h5210, 4'b0, "R2 neighbour group sequential");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule